// File: doc/BRIEF.md
# Unlock Sequence Command Decoder

This block watches the completed accesses of a memory port and spots two special read patterns. Each pattern is six reads long. The first five addresses are the same for both patterns: 0x4E38, 0xB1C7, 0x83E0, 0x7C1F and 0x703F, in that order. The sixth address picks the command. A read of 0x8FC0 asks the controller to copy the working array into nonvolatile storage (a save). A read of 0x4C63 asks it to load the array back from nonvolatile storage (a restore). When a pattern completes, the block raises a start pulse, one clock wide, on the matching output.

Each access is given by a one-cycle strobe, a write flag and an address. Any write breaks a partly entered pattern. So does any read whose address is not the expected next one. Neither breakage produces a command. After a start pulse, the decoder ignores all traffic until the controller raises its done signal. An output-enable qualifier plays no part in the pattern, so only the strobe and the write flag decide whether an access is a read.

Top module: `nv_unlock_decoder`

## Requirements
- R1: After reset, `save_start_o` and `restore_start_o` are low, and no partial pattern is retained.
- R2: Reads at 0x4E38, 0xB1C7, 0x83E0, 0x7C1F, 0x703F and then 0x8FC0, each taken with `acc_valid_i`=1 and `acc_write_i`=0, raise `save_start_o` in the cycle after the strobe of the sixth read.
- R3: The same five-read prefix followed by a read of 0x4C63 raises `restore_start_o` in the cycle after the sixth strobe.
- R4: A read whose address is not the expected next address discards the partial pattern, so completing the remaining steps afterwards gives no pulse. A sixth read at any address other than the two command addresses gives no pulse.
- R5: A write (`acc_write_i`=1) at any step discards the partial pattern, even when its address is the expected one, and it never produces a pulse.
- R6: A mismatching read at 0x4E38 counts as step one of a new pattern rather than returning the decoder to idle.
- R7: After a start pulse, accesses are ignored, including any access in the same cycle as `op_done_i`, until `op_done_i` has been seen high. A `op_done_i` seen while no command is pending has no effect.
- R8: Each start pulse is exactly one clock wide, the decoder is back at idle in that cycle, and the two start outputs are never high together.
- R9: Cycles without `acc_valid_i` leave the pattern state unchanged, so idle gaps between the steps do not abort a pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| acc_valid_i | input | 1 | One-cycle strobe marking a completed access |
| acc_write_i | input | 1 | 1 = write access, 0 = read access |
| acc_addr_i | input | ADDR_W (16) | Address of the access |
| op_done_i | input | 1 | Controller reports that the save or restore has finished |
| save_start_o | output | 1 | One-clock pulse that starts a save |
| restore_start_o | output | 1 | One-clock pulse that starts a restore |

## Verification
A corrupted step counter shows at the ports as a missing pulse, or as a pulse the pattern does not justify. The symptom appears one clock after the sixth strobe of the pattern that follows. A stuck lock shows as silence after `op_done_i`. A lost lock shows as a second pulse with no done in between. Either appears within one cycle of the next completed pattern. The directed tests therefore always finish with a full, legal pattern after each abort or lock scenario. That full pattern shows whether the internal state came back clean.

// File: rtl/nvu_pkg.sv
package nvu_pkg;
    localparam int unsigned ADDR_W     = 16;
    localparam int unsigned PREFIX_LEN = 5;

    // Element 0 is the first address of the pattern.
    localparam logic [PREFIX_LEN-1:0][ADDR_W-1:0] PREFIX_KEYS = {
        16'h703F, 16'h7C1F, 16'h83E0, 16'hB1C7, 16'h4E38
    };
    localparam logic [ADDR_W-1:0] SAVE_KEY    = 16'h8FC0;
    localparam logic [ADDR_W-1:0] RESTORE_KEY = 16'h4C63;

    typedef enum logic [1:0] {
        CMD_NONE    = 2'b00,
        CMD_SAVE    = 2'b01,
        CMD_RESTORE = 2'b10
    } cmd_e;
endpackage

// File: rtl/nvu_key_match.sv
module nvu_key_match #(
    parameter int unsigned ADDR_W     = nvu_pkg::ADDR_W,
    parameter int unsigned PREFIX_LEN = nvu_pkg::PREFIX_LEN,
    parameter logic [PREFIX_LEN-1:0][ADDR_W-1:0] PREFIX_KEYS = nvu_pkg::PREFIX_KEYS,
    parameter logic [ADDR_W-1:0] SAVE_KEY    = nvu_pkg::SAVE_KEY,
    parameter logic [ADDR_W-1:0] RESTORE_KEY = nvu_pkg::RESTORE_KEY,
    localparam int unsigned STEP_W = $clog2(PREFIX_LEN + 1)
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [STEP_W-1:0] step_i,
    output logic              step_hit_o,
    output logic              first_hit_o,
    output nvu_pkg::cmd_e     final_cmd_o
);
    logic [PREFIX_LEN-1:0] key_hit;

    // One comparator per prefix step.
    for (genvar g = 0; g < PREFIX_LEN; g++) begin : g_cmp
        assign key_hit[g] = (addr_i == PREFIX_KEYS[g]);
    end

    always_comb begin
        step_hit_o = 1'b0;
        for (int i = 0; i < PREFIX_LEN; i++) begin
            if (step_i == STEP_W'(i)) step_hit_o = key_hit[i];
        end
    end

    assign first_hit_o = key_hit[0];

    always_comb begin
        if (addr_i == SAVE_KEY)         final_cmd_o = nvu_pkg::CMD_SAVE;
        else if (addr_i == RESTORE_KEY) final_cmd_o = nvu_pkg::CMD_RESTORE;
        else                            final_cmd_o = nvu_pkg::CMD_NONE;
    end
endmodule

// File: rtl/nvu_lock.sv
module nvu_lock (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic set_i,
    input  logic done_i,
    output logic locked_o
);
    logic lock_d, lock_q;

    always_comb begin
        lock_d = lock_q;
        if (set_i)       lock_d = 1'b1;
        else if (done_i) lock_d = 1'b0;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) lock_q <= 1'b0;
        else         lock_q <= lock_d;
    end

    assign locked_o = lock_q;
endmodule

// File: rtl/nv_unlock_decoder.sv
module nv_unlock_decoder #(
    parameter int unsigned ADDR_W     = nvu_pkg::ADDR_W,
    parameter int unsigned PREFIX_LEN = nvu_pkg::PREFIX_LEN,
    parameter logic [PREFIX_LEN-1:0][ADDR_W-1:0] PREFIX_KEYS = nvu_pkg::PREFIX_KEYS,
    parameter logic [ADDR_W-1:0] SAVE_KEY    = nvu_pkg::SAVE_KEY,
    parameter logic [ADDR_W-1:0] RESTORE_KEY = nvu_pkg::RESTORE_KEY
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              acc_valid_i,
    input  logic              acc_write_i,
    input  logic [ADDR_W-1:0] acc_addr_i,
    input  logic              op_done_i,
    output logic              save_start_o,
    output logic              restore_start_o
);
    localparam int unsigned STEP_W = $clog2(PREFIX_LEN + 1);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(PREFIX_LEN);

    typedef struct packed {
        logic [STEP_W-1:0] step;
        logic              save;
        logic              restore;
    } state_t;

    state_t        st_d, st_q;
    logic          step_hit, first_hit, locked;
    nvu_pkg::cmd_e final_cmd;

    nvu_key_match #(
        .ADDR_W     (ADDR_W),
        .PREFIX_LEN (PREFIX_LEN),
        .PREFIX_KEYS(PREFIX_KEYS),
        .SAVE_KEY   (SAVE_KEY),
        .RESTORE_KEY(RESTORE_KEY)
    ) i_match (
        .addr_i     (acc_addr_i),
        .step_i     (st_q.step),
        .step_hit_o (step_hit),
        .first_hit_o(first_hit),
        .final_cmd_o(final_cmd)
    );

    nvu_lock i_lock (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .set_i   (st_d.save | st_d.restore),
        .done_i  (op_done_i),
        .locked_o(locked)
    );

    always_comb begin
        st_d         = st_q;
        st_d.save    = 1'b0;
        st_d.restore = 1'b0;
        if (acc_valid_i && !locked) begin
            if (acc_write_i) begin
                st_d.step = '0;
            end else if (st_q.step == LAST_STEP) begin
                st_d.step = first_hit ? STEP_W'(1) : '0;
                unique case (final_cmd)
                    nvu_pkg::CMD_SAVE: begin
                        st_d.save = 1'b1;
                        st_d.step = '0;
                    end
                    nvu_pkg::CMD_RESTORE: begin
                        st_d.restore = 1'b1;
                        st_d.step    = '0;
                    end
                    default: ;
                endcase
            end else if (step_hit) begin
                st_d.step = st_q.step + STEP_W'(1);
            end else begin
                st_d.step = first_hit ? STEP_W'(1) : '0;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign save_start_o    = st_q.save;
    assign restore_start_o = st_q.restore;
endmodule

// File: rtl/nvu_checker.sv
module nvu_checker #(
    parameter int unsigned ADDR_W = 16,
    parameter logic [ADDR_W-1:0] SAVE_KEY    = '0,
    parameter logic [ADDR_W-1:0] RESTORE_KEY = '0
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              acc_valid_i,
    input logic              acc_write_i,
    input logic [ADDR_W-1:0] acc_addr_i,
    input logic              op_done_i,
    input logic              save_start_o,
    input logic              restore_start_o
);
    logic pending_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni)                           pending_q <= 1'b0;
        else if (op_done_i)                    pending_q <= 1'b0;
        else if (save_start_o || restore_start_o) pending_q <= 1'b1;
    end

    assert_exclusive_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(save_start_o && restore_start_o));

    assert_save_width_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        save_start_o |=> !save_start_o);

    assert_restore_width_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        restore_start_o |=> !restore_start_o);

    assert_write_no_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (acc_valid_i && acc_write_i) |=> !(save_start_o || restore_start_o));

    assert_save_addr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(save_start_o) |-> $past(acc_valid_i && !acc_write_i && acc_addr_i == SAVE_KEY));

    assert_restore_addr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(restore_start_o) |-> $past(acc_valid_i && !acc_write_i && acc_addr_i == RESTORE_KEY));

    assert_locked_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (save_start_o || restore_start_o) |-> !pending_q);
endmodule

bind nv_unlock_decoder nvu_checker #(
    .ADDR_W     (ADDR_W),
    .SAVE_KEY   (SAVE_KEY),
    .RESTORE_KEY(RESTORE_KEY)
) i_nvu_checker (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .acc_valid_i    (acc_valid_i),
    .acc_write_i    (acc_write_i),
    .acc_addr_i     (acc_addr_i),
    .op_done_i      (op_done_i),
    .save_start_o   (save_start_o),
    .restore_start_o(restore_start_o)
);

// File: tb/test_nv_unlock_decoder.sv
module test_nv_unlock_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [15:0] acc_addr = '0;
    logic        op_done = 1'b0;
    logic        save_start, restore_start;
    int          n_checks = 0;
    int          n_fail = 0;

    localparam logic [15:0] K0 = 16'h4E38, K1 = 16'hB1C7, K2 = 16'h83E0,
                            K3 = 16'h7C1F, K4 = 16'h703F;
    localparam logic [15:0] KSAVE = 16'h8FC0, KREST = 16'h4C63;

    always #10 clk = ~clk;

    nv_unlock_decoder i_nv_unlock_decoder (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .acc_valid_i    (acc_valid),
        .acc_write_i    (acc_write),
        .acc_addr_i     (acc_addr),
        .op_done_i      (op_done),
        .save_start_o   (save_start),
        .restore_start_o(restore_start)
    );

    task automatic check(input bit ok, input string req, input logic [1:0] act, input logic [1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: {save,restore} actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic expect_out(input string req, input logic [1:0] exp);
        check({save_start, restore_start} == exp, req, {save_start, restore_start}, exp);
    endtask

    // One strobed access; returns at the negedge where its result is visible.
    task automatic access(input logic wr, input logic [15:0] a);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = wr; acc_addr = a;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a);
        access(1'b0, a);
    endtask

    task automatic done_pulse();
        @(negedge clk); op_done = 1'b1;
        @(negedge clk); op_done = 1'b0;
    endtask

    task automatic prefix();
        rd(K0); rd(K1); rd(K2); rd(K3); rd(K4);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        expect_out("R1 reset", 2'b00);
        rst_n = 1'b1;
        @(negedge clk);
        expect_out("R1 after release", 2'b00);
    endtask

    task automatic t_save();
        rd(K0); expect_out("R2 no early pulse", 2'b00);
        rd(K1); rd(K2); rd(K3); rd(K4);
        expect_out("R2 no pulse after prefix", 2'b00);
        rd(KSAVE);
        expect_out("R2 save pulse", 2'b10);
        @(negedge clk);
        expect_out("R8 pulse one clock", 2'b00);
        done_pulse();
    endtask

    task automatic t_restore();
        prefix(); rd(KREST);
        expect_out("R3 restore pulse", 2'b01);
        @(negedge clk);
        expect_out("R8 restore one clock", 2'b00);
        done_pulse();
    endtask

    task automatic t_lock();
        prefix(); rd(KSAVE);
        expect_out("R7 first pulse", 2'b10);
        prefix(); rd(KREST);
        expect_out("R7 ignored while pending", 2'b00);
        // access in the same cycle as done is still ignored
        @(negedge clk);
        op_done = 1'b1; acc_valid = 1'b1; acc_addr = K0;
        @(negedge clk);
        op_done = 1'b0; acc_valid = 1'b0;
        rd(K1); rd(K2); rd(K3); rd(K4); rd(KSAVE);
        expect_out("R7 access with done ignored", 2'b00);
        prefix(); rd(KSAVE);
        expect_out("R7 usable after done", 2'b10);
        done_pulse();
    endtask

    task automatic t_mismatch();
        rd(K0); rd(K1); rd(16'h1234); rd(K3); rd(K4); rd(KSAVE);
        expect_out("R4 mismatch aborts", 2'b00);
        prefix(); rd(16'h0000);
        expect_out("R4 wrong final address", 2'b00);
        rd(K1); rd(K2); rd(K3); rd(K4); rd(KSAVE);
        expect_out("R4 state cleared after bad final", 2'b00);
    endtask

    task automatic t_write();
        rd(K0); rd(K1); access(1'b1, K2);
        expect_out("R5 write no pulse", 2'b00);
        rd(K3); rd(K4); rd(KSAVE);
        expect_out("R5 write at expected address aborts", 2'b00);
        prefix(); access(1'b1, KREST);
        expect_out("R5 final write no pulse", 2'b00);
        rd(KREST);
        expect_out("R5 pattern gone after final write", 2'b00);
    endtask

    task automatic t_restart();
        rd(K0); rd(K1); rd(K0);
        rd(K1); rd(K2); rd(K3); rd(K4); rd(KREST);
        expect_out("R6 restart at step one", 2'b01);
        done_pulse();
        prefix(); rd(K0);
        rd(K1); rd(K2); rd(K3); rd(K4); rd(KSAVE);
        expect_out("R6 restart from final step", 2'b10);
        done_pulse();
    endtask

    task automatic t_gaps();
        done_pulse();
        rd(K0); repeat (4) @(negedge clk);
        rd(K1); rd(K2); repeat (7) @(negedge clk);
        expect_out("R9 idle gap quiet", 2'b00);
        rd(K3); rd(K4); repeat (2) @(negedge clk);
        rd(KSAVE);
        expect_out("R9 gaps do not abort, R7 idle done no effect", 2'b10);
        done_pulse();
    endtask

    initial begin
        t_reset();
        t_save();
        t_restore();
        t_lock();
        t_mismatch();
        t_write();
        t_restart();
        t_gaps();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule